// File: doc/BRIEF.md
# Stop-Grant Interrupt-Pending Notifier

This block sits on the processor side of a stop-clock handshake. While the stop-clock request is high, a pending interrupt can get stuck until the clock is released. The block prevents this by sending a wake notification toward the I/O hub before or alongside the stop-grant message. It offers two notification methods, chosen by a configuration bit:

- **I/O mode.** The block checks for a pending interrupt each time an I/O instruction retires. If one is pending, it issues a single byte-wide I/O-space access, either a read or a write.
- **Link mode.** The block checks when stop-grant entry is signalled. If an interrupt is pending, it sends an interrupt-pending link message first and the stop-grant message after it.

A disable bit lets the handler that services the wake event turn off I/O-mode generation, so its own I/O instructions do not trigger the mechanism again. At most one notification is issued per stop-clock assertion. Every outgoing transaction is a request that is held until its acknowledge arrives.

The configuration register is 32 bits wide and written through a plain write port:

| Bits | Meaning |
|---|---|
| [7:0] | I/O message address |
| [8] | Mode: 0 = I/O, 1 = link message |
| [9] | Direction: 0 = write, 1 = read |
| [10] | I/O-mode disable |
| [23:16] | Write data |

All other bits are ignored. The register resets to 0x00000400, which selects I/O mode with generation disabled. Writing 0x033300B0, for example, makes the block write 0x33 to I/O address 0xB0 when it fires.

Top module: `sg_wake_notifier`

## Requirements
- R1: After reset, io_req, ipend_msg_req and sg_msg_req are low, and the configuration has the disable bit [10] set, so a qualifying I/O retire issues no access until the configuration is rewritten.
- R2: In I/O mode (bit [8]=0, bit [10]=0), a cycle with io_retire, stpclk_req and intr_pending all high, while idle and armed, raises io_req in the next cycle with io_addr equal to configuration bits [7:0].
- R3: Configuration bit [9]=0 makes the access a write (io_is_rd=0) with io_wdata equal to bits [23:16]. Bit [9]=1 makes it a read (io_is_rd=1) with io_wdata driven to 0.
- R4: In I/O mode the check happens only on io_retire. A retire without intr_pending, a retire with stpclk_req low, or a stop-grant entry all leave io_req low.
- R5: Configuration bit [10]=1 suppresses I/O-mode access generation completely.
- R6: In link mode (bit [8]=1), io_retire has no effect. A cycle with sg_entry, stpclk_req and intr_pending high, while idle and armed, raises ipend_msg_req in the next cycle. In the cycle after ipend_msg_ack, sg_msg_req rises.
- R7: sg_entry with stpclk_req high always yields one sg_msg_req. With nothing else outstanding, sg_msg_req rises in the next cycle.
- R8: Only one notification (I/O access or interrupt-pending message) is issued per stop-clock assertion. Generation re-arms after stpclk_req has been low for at least one cycle.
- R9: If sg_entry arrives while an I/O access awaits acknowledge, sg_msg_req stays low until the acknowledge, then rises in the following cycle.
- R10: A request stays high with stable address and data until its acknowledge, and drops in the cycle after. At most one of the three requests is high at any time.
- R11: The configuration value 0x033300B0 produces a write of 0x33 to I/O address 0xB0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write value |
| stpclk_req | input | 1 | Stop-clock request level |
| intr_pending | input | 1 | An interrupt is pending |
| io_retire | input | 1 | Strobe: an I/O instruction completed |
| sg_entry | input | 1 | Strobe: stop-grant state is being entered |
| io_req | output | 1 | I/O-space byte access request |
| io_is_rd | output | 1 | Access is a read (1) or a write (0) |
| io_addr | output | 8 | I/O access address |
| io_wdata | output | 8 | Write data (0 for reads) |
| io_ack | input | 1 | I/O access acknowledge |
| ipend_msg_req | output | 1 | Interrupt-pending link message request |
| ipend_msg_ack | input | 1 | Interrupt-pending message acknowledge |
| sg_msg_req | output | 1 | Stop-grant message request |
| sg_msg_ack | input | 1 | Stop-grant message acknowledge |

## Verification
Each kind of internal fault shows up at the ports within one or two cycles:

- **Arm flag stuck.** A second notification appears within one stop-clock assertion, or none appears after a re-arm. This is visible one cycle after the triggering strobe.
- **Lost deferred stop-grant.** sg_msg_req fails to rise in the cycle after the I/O acknowledge.
- **Wrong latched access fields.** A wrong address, direction or data value is visible on the first cycle of io_req.

The bench compares all three requests and the access fields against a queue-based model on every cycle. A fault is therefore reported in the same cycle it first becomes visible.

// File: rtl/sgwn_pkg.sv
package sgwn_pkg;

    localparam int CFG_W     = 32;
    localparam int IO_ADDR_W = 8;
    localparam int IO_DATA_W = 8;

    localparam int ADDR_LSB  = 0;
    localparam int MODE_BIT  = 8;
    localparam int RD_BIT    = 9;
    localparam int DIS_BIT   = 10;
    localparam int DATA_LSB  = 16;

    typedef struct packed {
        logic                 link_mode;
        logic                 rd;
        logic                 dis;
        logic [IO_ADDR_W-1:0] addr;
        logic [IO_DATA_W-1:0] data;
    } cfg_t;

    typedef struct packed {
        logic                 rd;
        logic [IO_ADDR_W-1:0] addr;
        logic [IO_DATA_W-1:0] data;
    } io_txn_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IO   = 2'd1,
        ST_IPM  = 2'd2,
        ST_SG   = 2'd3
    } seq_st_e;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        cfg_t c;
        c.link_mode = raw[MODE_BIT];
        c.rd        = raw[RD_BIT];
        c.dis       = raw[DIS_BIT];
        c.addr      = raw[ADDR_LSB +: IO_ADDR_W];
        c.data      = raw[DATA_LSB +: IO_DATA_W];
        return c;
    endfunction

    function automatic io_txn_t make_txn(input cfg_t c);
        io_txn_t t;
        t.rd   = c.rd;
        t.addr = c.addr;
        t.data = c.rd ? '0 : c.data;
        return t;
    endfunction

endpackage

// File: rtl/sgwn_cfg_reg.sv
module sgwn_cfg_reg
    import sgwn_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = 32'h0000_0400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg_o
);
    logic [CFG_W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst)        raw_q <= RESET_VAL;
        else if (wr_en) raw_q <= wr_data;
    end

    assign cfg_o = decode_cfg(raw_q);
endmodule

// File: rtl/sgwn_trigger.sv
module sgwn_trigger
    import sgwn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic idle,
    input  logic stpclk,
    input  logic intr,
    input  logic io_retire,
    input  logic sg_entry,
    output logic io_hit,
    output logic link_hit,
    output logic sg_evt
);
    logic armed_q;

    assign sg_evt   = sg_entry && stpclk;
    assign io_hit   = idle && armed_q && !cfg.link_mode && !cfg.dis
                      && stpclk && intr && io_retire;
    assign link_hit = idle && armed_q && cfg.link_mode && intr && sg_evt;

    always_ff @(posedge clk) begin
        if (rst)                     armed_q <= 1'b1;
        else if (!stpclk)            armed_q <= 1'b1;
        else if (io_hit || link_hit) armed_q <= 1'b0;
    end
endmodule

// File: rtl/sgwn_seq.sv
module sgwn_seq
    import sgwn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_t    cfg,
    input  logic    io_hit,
    input  logic    link_hit,
    input  logic    sg_evt,
    input  logic    io_ack,
    input  logic    ipm_ack,
    input  logic    sg_ack,
    output logic    idle,
    output logic    io_req,
    output logic    ipm_req,
    output logic    sg_req,
    output io_txn_t txn
);
    seq_st_e st_q;
    logic    sg_owed_q;
    io_txn_t txn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            sg_owed_q <= 1'b0;
            txn_q     <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (io_hit) begin
                        st_q      <= ST_IO;
                        txn_q     <= make_txn(cfg);
                        sg_owed_q <= sg_evt;
                    end else if (sg_evt) begin
                        st_q <= link_hit ? ST_IPM : ST_SG;
                    end
                end
                ST_IO: begin
                    if (io_ack) begin
                        st_q      <= (sg_owed_q || sg_evt) ? ST_SG : ST_IDLE;
                        sg_owed_q <= 1'b0;
                    end else if (sg_evt) begin
                        sg_owed_q <= 1'b1;
                    end
                end
                ST_IPM: if (ipm_ack) st_q <= ST_SG;
                ST_SG:  if (sg_ack)  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (st_q == ST_IDLE);
    assign io_req  = (st_q == ST_IO);
    assign ipm_req = (st_q == ST_IPM);
    assign sg_req  = (st_q == ST_SG);
    assign txn     = txn_q;
endmodule

// File: rtl/sg_wake_notifier.sv
module sg_wake_notifier
    import sgwn_pkg::*;
#(
    parameter logic [CFG_W-1:0] CFG_RESET = 32'h0000_0400
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 stpclk_req,
    input  logic                 intr_pending,
    input  logic                 io_retire,
    input  logic                 sg_entry,
    output logic                 io_req,
    output logic                 io_is_rd,
    output logic [IO_ADDR_W-1:0] io_addr,
    output logic [IO_DATA_W-1:0] io_wdata,
    input  logic                 io_ack,
    output logic                 ipend_msg_req,
    input  logic                 ipend_msg_ack,
    output logic                 sg_msg_req,
    input  logic                 sg_msg_ack
);
    cfg_t    cfg;
    io_txn_t txn;
    logic    idle, io_hit, link_hit, sg_evt;

    sgwn_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_wdata), .cfg_o(cfg)
    );

    sgwn_trigger u_trig (
        .clk(clk), .rst(rst), .cfg(cfg), .idle(idle),
        .stpclk(stpclk_req), .intr(intr_pending),
        .io_retire(io_retire), .sg_entry(sg_entry),
        .io_hit(io_hit), .link_hit(link_hit), .sg_evt(sg_evt)
    );

    sgwn_seq u_seq (
        .clk(clk), .rst(rst), .cfg(cfg),
        .io_hit(io_hit), .link_hit(link_hit), .sg_evt(sg_evt),
        .io_ack(io_ack), .ipm_ack(ipend_msg_ack), .sg_ack(sg_msg_ack),
        .idle(idle), .io_req(io_req), .ipm_req(ipend_msg_req),
        .sg_req(sg_msg_req), .txn(txn)
    );

    assign io_is_rd = txn.rd;
    assign io_addr  = txn.addr;
    assign io_wdata = txn.data;
endmodule

// File: rtl/sgwn_chk.sv
module sgwn_chk
    import sgwn_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 stpclk_req,
    input logic                 intr_pending,
    input logic                 io_retire,
    input logic                 io_req,
    input logic                 io_is_rd,
    input logic [IO_ADDR_W-1:0] io_addr,
    input logic [IO_DATA_W-1:0] io_wdata,
    input logic                 io_ack,
    input logic                 ipend_msg_req,
    input logic                 ipend_msg_ack,
    input logic                 sg_msg_req
);
    // R10
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_req, ipend_msg_req, sg_msg_req}));

    // R10
    io_hold_chk: assert property (@(posedge clk) disable iff (rst)
        io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_wdata) && $stable(io_is_rd));

    // R3
    rd_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        io_req && io_is_rd |-> io_wdata == '0);

    // R4
    io_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_req) |-> $past(io_retire) && $past(stpclk_req) && $past(intr_pending));

    // R6
    ipm_then_sg_chk: assert property (@(posedge clk) disable iff (rst)
        ipend_msg_req && ipend_msg_ack |=> sg_msg_req);
endmodule

bind sg_wake_notifier sgwn_chk u_chk (
    .clk(clk), .rst(rst), .stpclk_req(stpclk_req), .intr_pending(intr_pending),
    .io_retire(io_retire), .io_req(io_req), .io_is_rd(io_is_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_ack(io_ack),
    .ipend_msg_req(ipend_msg_req), .ipend_msg_ack(ipend_msg_ack),
    .sg_msg_req(sg_msg_req)
);

// File: tb/sg_wake_notifier_tb_top.sv
module sg_wake_notifier_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        stpclk_req = 1'b0, intr_pending = 1'b0, io_retire = 1'b0, sg_entry = 1'b0;
    logic        io_ack = 1'b0, ipend_msg_ack = 1'b0, sg_msg_ack = 1'b0;
    logic        io_req, io_is_rd, ipend_msg_req, sg_msg_req;
    logic [7:0]  io_addr, io_wdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_wake_notifier dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stpclk_req(stpclk_req), .intr_pending(intr_pending),
        .io_retire(io_retire), .sg_entry(sg_entry),
        .io_req(io_req), .io_is_rd(io_is_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_ack(io_ack), .ipend_msg_req(ipend_msg_req), .ipend_msg_ack(ipend_msg_ack),
        .sg_msg_req(sg_msg_req), .sg_msg_ack(sg_msg_ack)
    );

    // Reference model: queue of outstanding messages.
    // Entry: [25:24] kind (1 io, 2 ipend, 3 stop-grant), [16] rd, [15:8] addr, [7:0] data
    logic [31:0] q[$];
    logic [31:0] m_cfg;
    bit          m_armed;

    function automatic bit q_has_sg();
        foreach (q[i]) if (q[i][25:24] == 2'd3) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_cfg   = 32'h0000_0400;
            m_armed = 1'b1;
        end else begin
            bit sgev, was_busy;
            logic [1:0] hk;
            sgev     = sg_entry && stpclk_req;
            was_busy = (q.size() != 0);
            hk       = was_busy ? q[0][25:24] : 2'd0;
            if (!was_busy) begin
                if (!m_cfg[8] && !m_cfg[10] && m_armed && stpclk_req && intr_pending && io_retire) begin
                    q.push_back({6'd0, 2'd1, 7'd0, m_cfg[9], m_cfg[7:0],
                                 m_cfg[9] ? 8'h00 : m_cfg[23:16]});
                    m_armed = 1'b0;
                    if (sgev) q.push_back({6'd0, 2'd3, 24'd0});
                end else if (sgev) begin
                    if (m_cfg[8] && m_armed && intr_pending) begin
                        q.push_back({6'd0, 2'd2, 24'd0});
                        m_armed = 1'b0;
                    end
                    q.push_back({6'd0, 2'd3, 24'd0});
                end
            end else begin
                if (sgev && !q_has_sg()) q.push_back({6'd0, 2'd3, 24'd0});
                if ((hk == 2'd1 && io_ack) || (hk == 2'd2 && ipend_msg_ack) || (hk == 2'd3 && sg_msg_ack))
                    void'(q.pop_front());
            end
            if (!stpclk_req) m_armed = 1'b1;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [1:0] hk;
            logic [31:0] e;
            hk = (q.size() != 0) ? q[0][25:24] : 2'd0;
            e  = (q.size() != 0) ? q[0] : 32'd0;
            check({phase, " R10 model reqs"}, {29'd0, io_req, ipend_msg_req, sg_msg_req},
                  {29'd0, hk == 2'd1, hk == 2'd2, hk == 2'd3});
            if (hk == 2'd1)
                check({phase, " R2 model fields"}, {15'd0, io_is_rd, io_addr, io_wdata}, {15'd0, e[16:0]});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_cfg(logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rearm();
        @(negedge clk); stpclk_req = 1'b0;
        @(negedge clk); stpclk_req = 1'b1;
    endtask

    task automatic pulse_retire();
        @(negedge clk); io_retire = 1'b1;
        @(negedge clk); io_retire = 1'b0;
    endtask

    task automatic pulse_sg();
        @(negedge clk); sg_entry = 1'b1;
        @(negedge clk); sg_entry = 1'b0;
    endtask

    task automatic ack(int which);
        @(negedge clk);
        case (which)
            1: io_ack = 1'b1;
            2: ipend_msg_ack = 1'b1;
            default: sg_msg_ack = 1'b1;
        endcase
        @(negedge clk);
        io_ack = 1'b0; ipend_msg_ack = 1'b0; sg_msg_ack = 1'b0;
    endtask

    function automatic logic [31:0] reqs();
        return {29'd0, io_req, ipend_msg_req, sg_msg_req};
    endfunction

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        phase = "R1";
        check("R1 reset reqs low", reqs(), 32'd0);
        stpclk_req = 1'b1; intr_pending = 1'b1;
        pulse_retire();
        check("R1 reset config disabled", reqs(), 32'd0);

        phase = "R11";
        write_cfg(32'h0333_00B0);
        rearm();
        pulse_retire();
        check("R11 io_req", reqs(), 32'd4);
        check("R11 write addr/data", {15'd0, io_is_rd, io_addr, io_wdata}, {15'd0, 1'b0, 8'hB0, 8'h33});
        phase = "R9";
        pulse_sg();
        tick();
        check("R10 io_req held", reqs(), 32'd4);
        check("R9 stop-grant deferred", {31'd0, sg_msg_req}, 32'd0);
        ack(1);
        check("R9 stop-grant after ack", reqs(), 32'd1);
        ack(3);
        check("R7 idle after sg ack", reqs(), 32'd0);

        phase = "R8";
        pulse_retire();
        check("R8 no second notification", reqs(), 32'd0);
        rearm();
        pulse_retire();
        check("R8 re-armed", reqs(), 32'd4);
        ack(1);
        check("R10 drop after ack", reqs(), 32'd0);

        phase = "R3";
        write_cfg(32'h00AA_0255);
        rearm();
        pulse_retire();
        check("R3 read access", {15'd0, io_is_rd, io_addr, io_wdata}, {15'd0, 1'b1, 8'h55, 8'h00});
        ack(1);
        write_cfg(32'h005A_0012);
        rearm();
        pulse_retire();
        check("R2 write addr/data", {15'd0, io_is_rd, io_addr, io_wdata}, {15'd0, 1'b0, 8'h12, 8'h5A});
        ack(1);

        phase = "R4";
        rearm();
        intr_pending = 1'b0;
        pulse_retire();
        check("R4 no intr no access", reqs(), 32'd0);
        intr_pending = 1'b1;
        stpclk_req = 1'b0;
        pulse_retire();
        check("R4 no stpclk no access", reqs(), 32'd0);
        stpclk_req = 1'b1;
        pulse_sg();
        check("R4 R7 sg only in io mode", reqs(), 32'd1);
        ack(3);

        phase = "R5";
        write_cfg(32'h0033_04B0);
        rearm();
        pulse_retire();
        check("R5 disabled", reqs(), 32'd0);

        phase = "R6";
        write_cfg(32'h0033_0100);
        rearm();
        pulse_retire();
        check("R6 retire ignored", reqs(), 32'd0);
        pulse_sg();
        check("R6 ipend msg first", reqs(), 32'd2);
        tick();
        check("R10 ipend held", reqs(), 32'd2);
        ack(2);
        check("R6 sg after ipend ack", reqs(), 32'd1);
        ack(3);
        pulse_sg();
        check("R8 link one per assertion", reqs(), 32'd1);
        ack(3);

        phase = "R7";
        rearm();
        intr_pending = 1'b0;
        pulse_sg();
        check("R7 sg without intr", reqs(), 32'd1);
        ack(3);
        repeat (3) tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule